// File: doc/BRIEF.md
# Package Idle State Coordinator

This block merges the idle-depth requests of a parameterised number of cores into one state per core and one shared package state. Each core asks for a depth on a 2-bit code: 0 means running, 1 means the core's clock is gated, 2 means interrupts are also held off, and 3 is the deepest level. Each core's own state tracks its request independently of the other cores. The clock-gate enable of a core depends only on that core's state.

The package state is the shallowest depth held by any core. A single core that stays in state 0 therefore keeps shared resources, such as clock generators, alive. The idle cores still gate their own clocks. Moving the package to a deeper state is deliberate: every core state must hold still for a programmable dwell before the move. Moving it to a shallower state is immediate.

A wake pulse on a core forces that core back to running and pulls the package to running in the same cycle. Interrupts are blocked while the package sits at depth 2 or deeper.

Top module: `pkg_idle_coord`

## Requirements
- R1: While reset is high, and right after it, every core state, the package state, every clock-gate enable and the interrupt block are all 0.
- R2: On each clock edge, a core's state takes that core's 2-bit request (0 run, 1 gated, 2 interrupts blocked, 3 deepest). The new state is visible one cycle after the request is applied.
- R3: A core's clock-gate enable is high exactly when that core's state is 1 or more. The package state has no effect on it.
- R4: Once settled, the package state equals the smallest of all core states, on a 2-bit code.
- R5: A deeper package state is taken only after all core states have stayed unchanged for `entry_dwell` cycles. With a request applied before edge E1, the package moves on edge E1+dwell+1.
- R6: Any change of any core state during the dwell window restarts the window. It is counted again from the edge of that change.
- R7: A wake pulse on a core forces that core to state 0 on the next edge, whatever its request. The package state reads 0 from that same edge.
- R8: When a core state drops below the package state, the package state drops to it in the same cycle, with no dwell.
- R9: The interrupt block output is high exactly when the package state is 2 or 3.
- R10: While any core is in state 0, the package state is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 2*NCORE | Requested depth per core, core i at bits [2i+1:2i] |
| wake | input | NCORE | Wake pulse per core |
| entry_dwell | input | CNT_W | Stable cycles needed before a deeper package state |
| core_state | output | 2*NCORE | Current depth per core |
| clk_gate | output | NCORE | Clock-gate enable per core |
| irq_block | output | 1 | Interrupts held off from the cores |
| pkg_state | output | 2 | Resolved package depth |

## Verification
A wake pulse and the end of the dwell window can land on the same edge. In that case the wake must win: the package stays at 0 instead of moving deeper. The bench provokes this by holding all cores at depth 3 for exactly dwell+1 cycles and then raising wake on one core just before the edge that would otherwise complete entry. It then expects core and package at 0 after that edge, and a fresh full dwell before depth 3 is reached. A full sweep of every request combination for three cores, at two dwell values, also puts exits, wakes and re-entries on every depth.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;

    localparam int DEPTH_W = 2;

    typedef enum logic [DEPTH_W-1:0] {
        D_RUN   = 2'd0,
        D_GATED = 2'd1,
        D_NOIRQ = 2'd2,
        D_DEEP  = 2'd3
    } depth_e;

    // Shallower of two depths.
    function automatic depth_e shallower(input depth_e a, input depth_e b);
        return (a < b) ? a : b;
    endfunction

    // A depth that holds off interrupts.
    function automatic logic blocks_irq(input depth_e d);
        return d >= D_NOIRQ;
    endfunction

endpackage

// File: rtl/idle_core_slot.sv
module idle_core_slot
    import idle_coord_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       wake,
    output depth_e     state,
    output logic       gate_en,
    output logic       will_change
);

    depth_e state_q;
    depth_e state_d;

    always_comb begin
        state_d = wake ? D_RUN : depth_e'(req);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= D_RUN;
        else     state_q <= state_d;
    end

    assign state       = state_q;
    assign gate_en     = (state_q != D_RUN);
    assign will_change = (state_d != state_q);

    // R7: wake forces running on the next edge
    a_r7_wake_runs: assert property (@(posedge clk) disable iff (rst)
        wake |=> (state == D_RUN));

    // R3: a non-zero request without wake gates the clock next cycle
    a_r3_gate_follows: assert property (@(posedge clk) disable iff (rst)
        (!wake && req != 2'd0) |=> gate_en);

endmodule

// File: rtl/idle_depth_min.sv
module idle_depth_min
    import idle_coord_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic [NCORE*DEPTH_W-1:0] states,
    output depth_e                   lowest
);

    depth_e chain [NCORE];

    assign chain[0] = depth_e'(states[DEPTH_W-1:0]);

    generate
        for (genvar i = 1; i < NCORE; i++) begin : g_chain
            assign chain[i] = shallower(chain[i-1],
                                        depth_e'(states[i*DEPTH_W +: DEPTH_W]));
        end
    endgenerate

    assign lowest = chain[NCORE-1];

endmodule

// File: rtl/idle_pkg_fsm.sv
module idle_pkg_fsm
    import idle_coord_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  depth_e           target,
    input  logic             changing,
    input  logic [CNT_W-1:0] dwell,
    output depth_e           pkg_state
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] stable_cnt;
    depth_e           pkg_q;
    logic             may_enter;

    assign may_enter = !changing && (stable_cnt >= dwell);

    always_ff @(posedge clk) begin
        if (rst)                       stable_cnt <= '0;
        else if (changing)             stable_cnt <= '0;
        else if (stable_cnt != CNT_MAX) stable_cnt <= stable_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                  pkg_q <= D_RUN;
        else if (target <= pkg_q) pkg_q <= target;
        else if (may_enter)       pkg_q <= target;
    end

    // Exit acts at once: the output never sits deeper than the cores.
    assign pkg_state = shallower(pkg_q, target);

    // R5: a deeper package register only after the dwell was met
    a_r5_entry_waits: assert property (@(posedge clk) disable iff (rst)
        (pkg_q > $past(pkg_q)) |-> ($past(stable_cnt) >= $past(dwell)));

    // R6: a change in core states clears the dwell count
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        changing |=> (stable_cnt == '0));

endmodule

// File: rtl/pkg_idle_coord.sv
module pkg_idle_coord
    import idle_coord_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCORE*2-1:0]     core_req,
    input  logic [NCORE-1:0]       wake,
    input  logic [CNT_W-1:0]       entry_dwell,
    output logic [NCORE*2-1:0]     core_state,
    output logic [NCORE-1:0]       clk_gate,
    output logic                   irq_block,
    output logic [1:0]             pkg_state
);

    logic [NCORE-1:0] chg_vec;
    depth_e           lowest;
    depth_e           pkg_d;

    generate
        for (genvar i = 0; i < NCORE; i++) begin : g_core
            depth_e st;
            idle_core_slot u_slot (
                .clk         (clk),
                .rst         (rst),
                .req         (core_req[i*DEPTH_W +: DEPTH_W]),
                .wake        (wake[i]),
                .state       (st),
                .gate_en     (clk_gate[i]),
                .will_change (chg_vec[i])
            );
            assign core_state[i*DEPTH_W +: DEPTH_W] = st;

            // R10: a running core pins the package to running
            a_r10_run_pins_pkg: assert property (@(posedge clk) disable iff (rst)
                (st == D_RUN) |-> (pkg_state == 2'd0));

            // R9: interrupt block implies this core is at depth 2 or deeper
            a_r9_irq_only_deep: assert property (@(posedge clk) disable iff (rst)
                irq_block |-> (st >= D_NOIRQ));
        end
    endgenerate

    idle_depth_min #(.NCORE(NCORE)) u_min (
        .states (core_state),
        .lowest (lowest)
    );

    idle_pkg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .target    (lowest),
        .changing  (|chg_vec),
        .dwell     (entry_dwell),
        .pkg_state (pkg_d)
    );

    assign pkg_state = pkg_d;
    assign irq_block = blocks_irq(pkg_d);

endmodule

// File: tb/pkg_idle_coord_bench.sv
module pkg_idle_coord_bench;

    localparam int N     = 3;
    localparam int CW    = 8;
    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*2-1:0]  core_req = '0;
    logic [N-1:0]    wake = '0;
    logic [CW-1:0]   entry_dwell = '0;
    logic [N*2-1:0]  core_state;
    logic [N-1:0]    clk_gate;
    logic            irq_block;
    logic [1:0]      pkg_state;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pkg_idle_coord #(.NCORE(N), .CNT_W(CW)) u_pkg_idle_coord (
        .clk(clk), .rst(rst), .core_req(core_req), .wake(wake),
        .entry_dwell(entry_dwell), .core_state(core_state),
        .clk_gate(clk_gate), .irq_block(irq_block), .pkg_state(pkg_state)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic drive(input int a, input int b, input int c);
        core_req = {2'(c), 2'(b), 2'(a)};
    endtask

    function automatic int st_of(input int i);
        return int'(core_state[i*2 +: 2]);
    endfunction

    task automatic chk_cores(input int a, input int b, input int c, input string tag);
        int e [3];
        e[0] = a; e[1] = b; e[2] = c;
        for (int i = 0; i < N; i++) begin
            chk(st_of(i) == e[i], {tag, " R2 core state"}, st_of(i), e[i]);
            chk(clk_gate[i] == (e[i] != 0), {tag, " R3 clock gate"}, int'(clk_gate[i]), int'(e[i] != 0));
        end
    endtask

    task automatic chk_pkg(input int m, input string tag);
        chk(int'(pkg_state) == m, tag, int'(pkg_state), m);
        chk(irq_block == (m >= 2), "R9 irq block", int'(irq_block), int'(m >= 2));
    endtask

    initial begin
        step(1);
        chk(core_state == '0 && pkg_state == 2'd0 && clk_gate == '0 && !irq_block,
            "R1 in reset", int'(core_state), 0);
        step(2);
        rst = 1'b0;
        step(1);
        chk(core_state == '0 && pkg_state == 2'd0 && clk_gate == '0 && !irq_block,
            "R1 after reset", int'(pkg_state), 0);

        // Sweep of every request combination at two dwell values.
        for (int di = 0; di < 2; di++) begin
            int d;
            d = (di == 0) ? 0 : 2;
            entry_dwell = CW'(d);
            for (int combo = 0; combo < 64; combo++) begin
                int a, b, c, m, w;
                a = combo % 4; b = (combo / 4) % 4; c = combo / 16;
                m = a; if (b < m) m = b; if (c < m) m = c;
                w = combo % 3;
                drive(0, 0, 0); wake = '0;
                step(2);
                drive(a, b, c);
                step(1);
                chk_cores(a, b, c, "sweep");
                step(d);
                chk(pkg_state == 2'd0, "R5 dwell not yet met", int'(pkg_state), 0);
                step(1);
                chk_pkg(m, "R4 package is minimum");
                chk_cores(a, b, c, "settled");
                if (m >= 2) begin
                    drive(a, 1, c);
                    step(1);
                    chk_pkg(1, "R8 immediate exit");
                    drive(a, b, c);
                    step(d + 2);
                    chk_pkg(m, "R5 re-entry after exit");
                end
                wake[w] = 1'b1;
                step(1);
                chk(st_of(w) == 0, "R7 woken core runs", st_of(w), 0);
                chk_pkg(0, "R7 package runs on wake");
                chk(clk_gate[w] == 1'b0, "R3 woken core ungated", int'(clk_gate[w]), 0);
                wake = '0;
                step(1);
                chk_cores(a, b, c, "after wake");
                chk(pkg_state == 2'd0, "R10 re-entry waits", int'(pkg_state), 0);
                step(d + 1);
                chk_pkg(m, "R5 re-entry after wake");
            end
        end

        // Restart of the dwell window on a change.
        entry_dwell = CW'(4);
        drive(1, 1, 1); step(7);
        chk_pkg(1, "R4 base depth 1");
        drive(3, 3, 3); step(3);
        chk_pkg(1, "R6 before change");
        drive(2, 3, 3);
        step(5);
        chk_pkg(1, "R6 window restarted");
        step(1);
        chk_pkg(2, "R6 entry after restart");

        // Wake on the very edge that would complete entry.
        entry_dwell = CW'(2);
        drive(0, 0, 0); step(2);
        drive(3, 3, 3); step(3);
        chk_pkg(0, "R5 still waiting");
        wake[0] = 1'b1;
        step(1);
        chk(st_of(0) == 0, "R7 collision core", st_of(0), 0);
        chk_pkg(0, "R7 collision package");
        wake = '0;
        step(3);
        chk_pkg(0, "R10 collision re-dwell");
        step(1);
        chk_pkg(3, "R5 collision re-entry");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule